// File: doc/BRIEF.md
# Carry-select adder

An 8-bit unsigned adder with a carry input, built to shorten the carry path across the upper half. The lower four bits are added by a ripple chain of full-adder cells fed by the external carry. At the same time, two separate ripple chains work on the upper four bits. One of them assumes the lower half produces no carry and the other assumes it does.

When the carry out of the lower half settles, it drives a bank of 2:1 multiplexers. These pick the upper sum bits and the final carry from whichever precomputed result matches. The upper half therefore costs one multiplexer delay after the lower carry, not a second ripple.

The block is purely combinational and has no clock or reset. Its operands flow straight through, so there is no valid/ready handshake. The caller samples the outputs whenever its own timing allows.

Top module: `csel_adder`

## Requirements
- R1: Output bits sum_o[3:0] equal bits [3:0] of a_i + b_i + cin_i.
- R2: Output bits sum_o[7:4] equal bits [7:4] of a_i + b_i + cin_i.
- R3: Output cout_o equals bit 8 of the 9-bit value a_i + b_i + cin_i.
- R4: The concatenation {cout_o, sum_o} equals a_i + b_i + cin_i for every one of the 2^17 input combinations.
- R5: When a_i[3:0] + b_i[3:0] + cin_i is below 16 (no carry out of the lower half), {cout_o, sum_o[7:4]} equals a_i[7:4] + b_i[7:4].
- R6: When a_i[3:0] + b_i[3:0] + cin_i is 16 or more, {cout_o, sum_o[7:4]} equals a_i[7:4] + b_i[7:4] + 1.
- R7: A carry that must cross every bit position is handled:
  - 0xFF + 0x00 + 1 gives sum 0x00 with carry 1.
  - 0x0F + 0x01 + 0 gives 0x10 with carry 0.
- R8: The 5-bit result of the upper section that assumes a carry is exactly one more than the 5-bit result of the section that assumes none.
- R9: The outputs follow a change of any input without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand, unsigned |
| b_i | input | 8 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 8 | Sum bits |
| cout_o | output | 1 | Carry out of bit 7 |

## Verification
Immediate assertions re-evaluate on every input change and check three things:
- each ripple chain against arithmetic;
- that the two speculative upper results differ by exactly one;
- that the chosen upper result matches the speculation implied by the lower carry.

Only the bench's sweep shows that every one of the 2^17 operand and carry combinations produces the right sum and carry. The bench also drives the named boundary patterns, such as a carry that crosses all eight bits, and confirms the outputs settle within the same cycle with no clock involved.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned CSEL_WIDTH = 8;
  localparam int unsigned CSEL_LO_W  = 4;
endpackage

// File: rtl/csel_fa.sv
module csel_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  logic gen_w;
  logic prop_w;

  assign gen_w  = x_i & y_i;
  assign prop_w = x_i ^ y_i;
  assign s_o    = prop_w ^ z_i;
  assign c_o    = gen_w | (prop_w & z_i);
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] chain;

  assign chain[0] = c_i;

  for (genvar k = 0; k < W; k++) begin : g_cell
    csel_fa u_fa (
      .x_i(a_i[k]),
      .y_i(b_i[k]),
      .z_i(chain[k]),
      .s_o(s_o[k]),
      .c_o(chain[k+1])
    );
  end

  assign c_o = chain[W];

  // Arithmetic reference for the cell chain
  logic [W:0] ref_w;
  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};

  always_comb begin
    p_chain_sum_r4: assert ({c_o, s_o} == ref_w)
      else $error("ripple chain disagrees with arithmetic");
  end
endmodule

// File: rtl/csel_mux2.sv
module csel_mux2 #(
  parameter int unsigned W = 5
) (
  input  logic         sel_i,
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  output logic [W-1:0] y_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign y_o[k] = sel_i ? d1_i[k] : d0_i[k];
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int unsigned WIDTH = csel_pkg::CSEL_WIDTH,
  parameter int unsigned LO_W  = csel_pkg::CSEL_LO_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned HI_W = WIDTH - LO_W;

  logic [LO_W-1:0] lo_sum;
  logic            lo_carry;
  logic [HI_W-1:0] hi_sum_n;
  logic            hi_cout_n;
  logic [HI_W-1:0] hi_sum_c;
  logic            hi_cout_c;
  logic [HI_W:0]   hi_pick;

  // Lower half, fed by the external carry
  csel_ripple #(.W(LO_W)) u_lo (
    .a_i(a_i[LO_W-1:0]),
    .b_i(b_i[LO_W-1:0]),
    .c_i(cin_i),
    .s_o(lo_sum),
    .c_o(lo_carry)
  );

  // Upper half, speculating no incoming carry
  csel_ripple #(.W(HI_W)) u_hi_nocarry (
    .a_i(a_i[WIDTH-1:LO_W]),
    .b_i(b_i[WIDTH-1:LO_W]),
    .c_i(1'b0),
    .s_o(hi_sum_n),
    .c_o(hi_cout_n)
  );

  // Upper half, speculating an incoming carry
  csel_ripple #(.W(HI_W)) u_hi_carry (
    .a_i(a_i[WIDTH-1:LO_W]),
    .b_i(b_i[WIDTH-1:LO_W]),
    .c_i(1'b1),
    .s_o(hi_sum_c),
    .c_o(hi_cout_c)
  );

  // HI_W sum bits plus the carry, steered by the real lower carry
  csel_mux2 #(.W(HI_W + 1)) u_sel (
    .sel_i(lo_carry),
    .d0_i({hi_cout_n, hi_sum_n}),
    .d1_i({hi_cout_c, hi_sum_c}),
    .y_o(hi_pick)
  );

  assign sum_o  = {hi_pick[HI_W-1:0], lo_sum};
  assign cout_o = hi_pick[HI_W];

  // Reference values used by the assertions below
  logic [WIDTH:0] total_ref;
  logic [HI_W:0]  hi_base;

  assign total_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign hi_base   = {1'b0, a_i[WIDTH-1:LO_W]} + {1'b0, b_i[WIDTH-1:LO_W]};

  always_comb begin
    p_spec_pair_r8: assert ({hi_cout_c, hi_sum_c} == {hi_cout_n, hi_sum_n} + 1'b1)
      else $error("speculative upper results do not differ by one");

    p_full_sum_r4: assert ({cout_o, sum_o} == total_ref)
      else $error("adder result differs from a+b+cin");

    if (!lo_carry) begin
      p_pick_plain_r5: assert ({cout_o, sum_o[WIDTH-1:LO_W]} == hi_base)
        else $error("upper half wrong with no lower carry");
    end else begin
      p_pick_inc_r6: assert ({cout_o, sum_o[WIDTH-1:LO_W]} == hi_base + 1'b1)
        else $error("upper half wrong with lower carry");
    end
  end
endmodule

// File: tb/sim_csel_adder.sv
module sim_csel_adder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic       cin = 1'b0;
  logic [7:0] sum;
  logic       cout;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  csel_adder u0 (
    .a_i(a),
    .b_i(b),
    .cin_i(cin),
    .sum_o(sum),
    .cout_o(cout)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%02h b=%02h cin=%0b actual=%0h expected=%0h",
               req, a, b, cin, act, exp);
    end
  endtask

  task automatic check_all();
    logic [8:0] full;
    logic [4:0] lo;
    logic [4:0] hi;
    full = {1'b0, a} + {1'b0, b} + {8'd0, cin};
    lo   = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
    hi   = {1'b0, a[7:4]} + {1'b0, b[7:4]};
    chk("R1", {5'd0, sum[3:0]}, {5'd0, full[3:0]});
    chk("R2", {5'd0, sum[7:4]}, {5'd0, full[7:4]});
    chk("R3", {8'd0, cout}, {8'd0, full[8]});
    chk("R4", {cout, sum}, full);
    if (!lo[4]) chk("R5", {4'd0, cout, sum[7:4]}, {4'd0, hi});
    else        chk("R6", {4'd0, cout, sum[7:4]}, {4'd0, hi + 5'd1});
  endtask

  task automatic apply(input logic [7:0] av, input logic [7:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R3 idle state: zero inputs give zero outputs
    chk("R1", {cout, sum}, 9'd0);

    // R4 exhaustive sweep of all operand and carry combinations
    for (int v = 0; v < 131072; v++) begin
      apply(v[7:0], v[15:8], v[16]);
      check_all();
    end

    // R7 carries crossing all bit positions
    apply(8'hFF, 8'h00, 1'b1);
    chk("R7", {cout, sum}, 9'h100);
    apply(8'h0F, 8'h01, 1'b0);
    chk("R7", {cout, sum}, 9'h010);
    apply(8'hFF, 8'hFF, 1'b1);
    chk("R7", {cout, sum}, 9'h1FF);

    // R8 upper half with and without lower carry differs by one
    apply(8'h70, 8'h10, 1'b0);
    chk("R8", {cout, sum}, 9'h080);
    apply(8'h7F, 8'h11, 1'b0);
    chk("R8", {cout, sum}, 9'h090);

    // R9 outputs follow inputs with no clock edge in between
    @(negedge clk);
    a = 8'h3C; b = 8'h45; cin = 1'b1;
    #1;
    chk("R9", {cout, sum}, 9'h082);
    a = 8'hC8; b = 8'h38; cin = 1'b0;
    #1;
    chk("R9", {cout, sum}, 9'h100);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule